// File: doc/BRIEF.md
# One-Wire Timeslot Generator

This block is the bus master for a single open-drain one-wire line. It produces the low-level timeslots and nothing above them. A command carries one of four operation codes: bus reset with presence detection, write of one bit, read of one bit, or a combined touch. Each command becomes a fixed sequence of phases. In the first phase the line is pulled low. In the later phases the line is released, and the block may sample it once at a fixed point. When the slot ends, the block returns one result bit together with a one-cycle completion strobe.

The slot timing is counted in microseconds. An internal prescaler divides the system clock by `CLK_PER_US` to make a one-microsecond tick. The prescaler restarts when a command is accepted, so every slot is aligned to that cycle. `DELAY_SCALE` multiplies every interval, and `RECOVERY_US` sets the quiet time after a presence sample. The line input passes through a two-flop synchronizer before it is sampled.

The command side is a valid/ready sink. The block accepts one command only when both `cmd_valid` and `cmd_ready` are high at a clock edge. It holds `cmd_ready` low until the slot has fully ended, so a command presented while the block is busy waits and is never queued. The response side is a plain strobe with no back-pressure: `rsp_bit` is valid only in the cycle in which `rsp_valid` is high. A synchronous reset aborts any slot in progress.

Top module: `owire_slot_gen`

## Requirements
- R1: After a synchronous reset, `line_drive_low` is 0, `cmd_ready` is 1 and `rsp_valid` is 0.
- R2: A write command (`cmd_op`=1) with `cmd_bit`=1 pulls the line low for 6 us, then releases it for 64 us, and returns `rsp_bit`=0 whatever the line level.
- R3: A write command with `cmd_bit`=0 pulls the line low for 60 us, then releases it for 10 us.
- R4: A read command (`cmd_op`=2) pulls the line low for 6 us and then releases it. It samples the synchronized line 9 us after the release, finishes 55 us after the sample, and returns the sampled level.
- R5: A reset command (`cmd_op`=0) pulls the line low for 500 us and samples the line 70 us after the release. It returns the sampled level, so 0 means a device answered.
- R6: After the presence sample, a reset command waits `RECOVERY_US` (default 430) further microseconds before it completes and accepts a new command.
- R7: Measured from the accepting edge, every interval lasts us × `DELAY_SCALE` × `CLK_PER_US` clock cycles. `rsp_valid` rises in the cycle after the final edge of the slot.
- R8: A touch command (`cmd_op`=3) with `cmd_bit`=1 performs a read slot and returns the sampled level. With `cmd_bit`=0 it performs a write-0 slot and returns 0.
- R9: `cmd_ready` is low from the accepting edge until the cycle in which `rsp_valid` pulses. A command held valid during that time has no effect.
- R10: The block never drives the line high. Whenever it is idle it leaves the line released (`line_drive_low`=0), and it raises `rsp_valid` for exactly one cycle per command.
- R11: A synchronous reset during a slot releases the line and raises `cmd_ready` by the next cycle, and no response is produced for the aborted slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_op | input | 2 | 0 reset/presence, 1 write, 2 read, 3 touch |
| cmd_bit | input | 1 | Bit to write or touch |
| rsp_valid | output | 1 | One-cycle slot completion strobe |
| rsp_bit | output | 1 | Sampled level or presence (0 = present); 0 for writes |
| line_in | input | 1 | Level of the bus line |
| line_drive_low | output | 1 | Open-drain pull-down enable |

## Verification
A wrong phase or a wrong counter value in this block shows up on `line_drive_low` as a low pulse of the wrong length. It is visible within one microsecond tick of the point where the correct pulse should have ended. A sample taken at the wrong moment only shows in `rsp_bit`, and only when a device pulse ends between the true sampling point and the wrong one. For that reason the tests place the edges of device pulses a few cycles on each side of that point. A state machine that is stuck or skips a phase shows as `cmd_ready` rising early or late, or as a missing or repeated `rsp_valid`.

// File: rtl/owire_pkg.sv
package owire_pkg;

  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_TOUCH = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    SLOT_W1  = 2'd0,
    SLOT_W0  = 2'd1,
    SLOT_RD  = 2'd2,
    SLOT_RST = 2'd3
  } slot_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_GAP  = 2'd2,
    PH_TAIL = 2'd3
  } phase_e;

  // slot intervals in microseconds before scaling
  localparam int W1_LOW_US  = 6;
  localparam int W1_REL_US  = 64;
  localparam int W0_LOW_US  = 60;
  localparam int W0_REL_US  = 10;
  localparam int RD_LOW_US  = 6;
  localparam int RD_GAP_US  = 9;
  localparam int RD_TAIL_US = 55;
  localparam int RST_LOW_US = 500;
  localparam int RST_GAP_US = 70;

  // map an operation code and bit onto the slot shape it produces
  function automatic slot_e slot_of(input logic [1:0] op, input logic b);
    slot_e s;
    case (op)
      2'd0:    s = SLOT_RST;
      2'd1:    s = b ? SLOT_W1 : SLOT_W0;
      2'd2:    s = SLOT_RD;
      default: s = b ? SLOT_RD : SLOT_W0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/owire_us_tick.sv
// Prescaler: one-cycle tick every DIV clocks, restartable.
module owire_us_tick #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/owire_slot_table.sv
// Scaled phase lengths for each slot shape.
module owire_slot_table
  import owire_pkg::*;
#(
  parameter int DELAY_SCALE = 1,
  parameter int RECOVERY_US = 430,
  parameter int CNT_W       = 10
) (
  input  slot_e            slot,
  output logic [CNT_W-1:0] low_len,
  output logic [CNT_W-1:0] gap_len,
  output logic [CNT_W-1:0] tail_len,
  output logic             has_sample
);
  localparam logic [CNT_W-1:0] L_W1   = CNT_W'(W1_LOW_US  * DELAY_SCALE);
  localparam logic [CNT_W-1:0] T_W1   = CNT_W'(W1_REL_US  * DELAY_SCALE);
  localparam logic [CNT_W-1:0] L_W0   = CNT_W'(W0_LOW_US  * DELAY_SCALE);
  localparam logic [CNT_W-1:0] T_W0   = CNT_W'(W0_REL_US  * DELAY_SCALE);
  localparam logic [CNT_W-1:0] L_RD   = CNT_W'(RD_LOW_US  * DELAY_SCALE);
  localparam logic [CNT_W-1:0] G_RD   = CNT_W'(RD_GAP_US  * DELAY_SCALE);
  localparam logic [CNT_W-1:0] T_RD   = CNT_W'(RD_TAIL_US * DELAY_SCALE);
  localparam logic [CNT_W-1:0] L_RST  = CNT_W'(RST_LOW_US * DELAY_SCALE);
  localparam logic [CNT_W-1:0] G_RST  = CNT_W'(RST_GAP_US * DELAY_SCALE);
  localparam logic [CNT_W-1:0] T_RST  = CNT_W'(RECOVERY_US * DELAY_SCALE);

  always_comb begin
    low_len    = L_W1;
    gap_len    = '0;
    tail_len   = T_W1;
    has_sample = 1'b0;
    case (slot)
      SLOT_W1: begin
        low_len  = L_W1;
        tail_len = T_W1;
      end
      SLOT_W0: begin
        low_len  = L_W0;
        tail_len = T_W0;
      end
      SLOT_RD: begin
        low_len    = L_RD;
        gap_len    = G_RD;
        tail_len   = T_RD;
        has_sample = 1'b1;
      end
      default: begin
        low_len    = L_RST;
        gap_len    = G_RST;
        tail_len   = T_RST;
        has_sample = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/owire_phase_timer.sv
// Counts microsecond ticks for the current phase; expire marks its last edge.
module owire_phase_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  assign expire = tick && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst)                        cnt_q <= '0;
    else if (load)                  cnt_q <= load_val;
    else if (tick && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/owire_in_sync.sv
// Synchronizer for the line input; resets to the released (high) level.
module owire_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '1;
        else     sh_q <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '1;
        else     sh_q <= {sh_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/owire_slot_gen.sv
module owire_slot_gen
  import owire_pkg::*;
#(
  parameter int CLK_PER_US  = 50,
  parameter int DELAY_SCALE = 1,
  parameter int RECOVERY_US = 430,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [1:0] cmd_op,
  input  logic       cmd_bit,
  output logic       rsp_valid,
  output logic       rsp_bit,
  input  logic       line_in,
  output logic       line_drive_low
);
  localparam int MAX_US  = (RECOVERY_US > RST_LOW_US) ? RECOVERY_US : RST_LOW_US;
  localparam int MAX_LEN = MAX_US * DELAY_SCALE;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  phase_e phase_q;
  slot_e  slot_q;
  logic   result_q;
  logic   done_q;

  logic   accept;
  slot_e  cmd_slot;
  slot_e  tbl_slot;
  logic   tick;
  logic   expire;
  logic   line_s;
  logic   tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic [CNT_W-1:0] low_len, gap_len, tail_len;
  logic   has_sample;

  assign cmd_ready = (phase_q == PH_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign cmd_slot  = slot_of(cmd_op, cmd_bit);
  assign tbl_slot  = accept ? cmd_slot : slot_q;

  owire_us_tick #(.DIV(CLK_PER_US)) u_tick (
    .clk (clk),
    .rst (rst),
    .clr (accept),
    .tick(tick)
  );

  owire_slot_table #(
    .DELAY_SCALE(DELAY_SCALE),
    .RECOVERY_US(RECOVERY_US),
    .CNT_W      (CNT_W)
  ) u_table (
    .slot      (tbl_slot),
    .low_len   (low_len),
    .gap_len   (gap_len),
    .tail_len  (tail_len),
    .has_sample(has_sample)
  );

  owire_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (line_in),
    .q  (line_s)
  );

  // timer reload at accept and at every phase change that has a successor
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = low_len;
    case (phase_q)
      PH_IDLE: begin
        tmr_load = accept;
        tmr_val  = low_len;
      end
      PH_LOW: begin
        tmr_load = expire;
        tmr_val  = has_sample ? gap_len : tail_len;
      end
      PH_GAP: begin
        tmr_load = expire;
        tmr_val  = tail_len;
      end
      default: begin
        tmr_load = 1'b0;
        tmr_val  = tail_len;
      end
    endcase
  end

  owire_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .load_val(tmr_val),
    .tick    (tick),
    .expire  (expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_IDLE;
      slot_q   <= SLOT_W1;
      result_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase_q)
        PH_IDLE: begin
          if (accept) begin
            phase_q  <= PH_LOW;
            slot_q   <= cmd_slot;
            result_q <= 1'b0;
          end
        end
        PH_LOW: begin
          if (expire) phase_q <= has_sample ? PH_GAP : PH_TAIL;
        end
        PH_GAP: begin
          if (expire) begin
            phase_q  <= PH_TAIL;
            result_q <= line_s;
          end
        end
        default: begin
          if (expire) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end
        end
      endcase
    end
  end

  assign line_drive_low = (phase_q == PH_LOW);
  assign rsp_valid      = done_q;
  assign rsp_bit        = result_q;

endmodule

// File: rtl/owire_slot_chk.sv
module owire_slot_chk
  import owire_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [1:0] cmd_op,
  input logic       cmd_bit,
  input logic       rsp_valid,
  input logic       rsp_bit,
  input logic       line_drive_low
);
  logic wr_q;

  always_ff @(posedge clk) begin
    if (rst) wr_q <= 1'b0;
    else if (cmd_valid && cmd_ready)
      wr_q <= (cmd_op == 2'd1) || (cmd_op == 2'd3 && !cmd_bit);
  end

  // R9: accepted command makes the block busy on the next cycle
  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  // R9: ready returns only together with the completion strobe
  p_ready_with_done_r9: assert property (@(posedge clk) disable iff (rst)
    ($rose(cmd_ready) && !$past(rst)) |-> rsp_valid);

  // R10: idle means released line
  p_idle_released_r10: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> !line_drive_low);

  // R10: completion strobe lasts one cycle
  p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R7: every slot opens with a low phase
  p_slot_starts_low_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> line_drive_low);

  // R8: writes and zero-touches answer 0
  p_write_answers_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && wr_q) |-> !rsp_bit);

endmodule

bind owire_slot_gen owire_slot_chk i_chk (
  .clk           (clk),
  .rst           (rst),
  .cmd_valid     (cmd_valid),
  .cmd_ready     (cmd_ready),
  .cmd_op        (cmd_op),
  .cmd_bit       (cmd_bit),
  .rsp_valid     (rsp_valid),
  .rsp_bit       (rsp_bit),
  .line_drive_low(line_drive_low)
);

// File: tb/test_owire_slot_gen.sv
`timescale 1ns/1ps
module test_owire_slot_gen;
  localparam int CPU = 5;
  localparam int SC  = 2;
  localparam int REC = 430;
  localparam int F   = CPU * SC;   // cycles per scaled microsecond

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [1:0] cmd_op = 2'd0;
  logic cmd_bit = 1'b0;
  logic rsp_valid, rsp_bit;
  logic line_drive_low;
  logic dev_pull = 1'b0;
  logic line_in;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  assign line_in = !(line_drive_low || dev_pull);

  always #10 clk = ~clk;

  owire_slot_gen #(
    .CLK_PER_US (CPU),
    .DELAY_SCALE(SC),
    .RECOVERY_US(REC)
  ) i_owire_slot_gen (
    .clk           (clk),
    .rst           (rst),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .cmd_op        (cmd_op),
    .cmd_bit       (cmd_bit),
    .rsp_valid     (rsp_valid),
    .rsp_bit       (rsp_bit),
    .line_in       (line_in),
    .line_drive_low(line_drive_low)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Issue one command and watch it. Negedge k is the k-th cycle after the
  // accepting edge. dev_pull is active for k in [ds, de).
  task automatic run_slot(input logic [1:0] op, input logic b,
                          input int ds, input int de, input int poke,
                          output int n_low, output int n_tot,
                          output logic bit_o, output int rdy_bad);
    int k;
    n_low = 0; n_tot = 0; bit_o = 1'b0; rdy_bad = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_bit = b;
    @(posedge clk);
    k = 0;
    while (1) begin
      @(negedge clk);
      k++;
      if (k > poke) cmd_valid = 1'b0;
      else begin cmd_op = 2'd2; cmd_bit = 1'b1; end
      dev_pull = (k >= ds) && (k < de);
      if (line_drive_low) n_low++;
      if (rsp_valid) begin
        n_tot = k; bit_o = rsp_bit;
        break;
      end
      if (cmd_ready) rdy_bad++;
      if (k > 30000) begin
        chk(1'b0, "R7", "slot never completed", k, 0);
        break;
      end
    end
    dev_pull = 1'b0;
    cmd_valid = 1'b0;
  endtask

  task automatic quiet(input string req, input int cycles);
    int bad = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (line_drive_low || rsp_valid || !cmd_ready) bad++;
    end
    chk(bad == 0, req, "idle line/strobe/ready disturbed", bad, 0);
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    chk(line_drive_low == 1'b0, "R1", "drive after reset", line_drive_low, 0);
    chk(cmd_ready == 1'b1, "R1", "ready after reset", cmd_ready, 1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
  endtask

  task automatic t_write1;
    int nl, nt, rb; logic bo;
    run_slot(2'd1, 1'b1, 61, 400, 0, nl, nt, bo, rb);
    chk(nl == 6 * F, "R2", "write-1 low cycles", nl, 6 * F);
    chk(nt == 70 * F + 1, "R7", "write-1 strobe cycle", nt, 70 * F + 1);
    chk(bo == 1'b0, "R2", "write-1 result", bo, 0);
    quiet("R10", 30);
  endtask

  task automatic t_write0;
    int nl, nt, rb; logic bo;
    run_slot(2'd1, 1'b0, 0, 0, 0, nl, nt, bo, rb);
    chk(nl == 60 * F, "R3", "write-0 low cycles", nl, 60 * F);
    chk(nt == 70 * F + 1, "R3", "write-0 strobe cycle", nt, 70 * F + 1);
    chk(bo == 1'b0, "R3", "write-0 result", bo, 0);
  endtask

  task automatic t_read;
    int nl, nt, rb; logic bo;
    // sample at 15 us after accept = edge 150; device pulse ends before it
    run_slot(2'd2, 1'b1, 61, 15 * F - 10, 0, nl, nt, bo, rb);
    chk(nl == 6 * F, "R4", "read low cycles", nl, 6 * F);
    chk(nt == 70 * F + 1, "R4", "read strobe cycle", nt, 70 * F + 1);
    chk(bo == 1'b1, "R4", "read early-ending pulse", bo, 1);
    // device pulse spans the sample point
    run_slot(2'd2, 1'b1, 61, 15 * F + 10, 0, nl, nt, bo, rb);
    chk(bo == 1'b0, "R4", "read device low", bo, 0);
    // device pulse starts after the sample point
    run_slot(2'd2, 1'b1, 15 * F + 10, 40 * F, 0, nl, nt, bo, rb);
    chk(bo == 1'b1, "R4", "read late pulse", bo, 1);
  endtask

  task automatic t_presence;
    int nl, nt, rb; logic bo;
    // sample at 570 us after accept
    run_slot(2'd0, 1'b0, 520 * F, 580 * F, 0, nl, nt, bo, rb);
    chk(nl == 500 * F, "R5", "reset low cycles", nl, 500 * F);
    chk(bo == 1'b0, "R5", "presence with device", bo, 0);
    chk(nt - 1 - 570 * F == REC * F, "R6", "recovery cycles", nt - 1 - 570 * F, REC * F);
    run_slot(2'd0, 1'b0, 0, 0, 0, nl, nt, bo, rb);
    chk(bo == 1'b1, "R5", "presence with no device", bo, 1);
    run_slot(2'd0, 1'b0, 520 * F, 560 * F, 0, nl, nt, bo, rb);
    chk(bo == 1'b1, "R5", "pulse over before sample", bo, 1);
    chk(nt == (570 + REC) * F + 1, "R6", "reset strobe cycle", nt, (570 + REC) * F + 1);
  endtask

  task automatic t_touch;
    int nl, nt, rb; logic bo;
    run_slot(2'd3, 1'b1, 61, 15 * F + 10, 0, nl, nt, bo, rb);
    chk(nl == 6 * F, "R8", "touch-1 low cycles", nl, 6 * F);
    chk(bo == 1'b0, "R8", "touch-1 sampled device", bo, 0);
    run_slot(2'd3, 1'b1, 0, 0, 0, nl, nt, bo, rb);
    chk(bo == 1'b1, "R8", "touch-1 released line", bo, 1);
    run_slot(2'd3, 1'b0, 0, 0, 0, nl, nt, bo, rb);
    chk(nl == 60 * F, "R8", "touch-0 low cycles", nl, 60 * F);
    chk(nt == 70 * F + 1, "R8", "touch-0 strobe cycle", nt, 70 * F + 1);
    chk(bo == 1'b0, "R8", "touch-0 result", bo, 0);
  endtask

  task automatic t_busy;
    int nl, nt, rb; logic bo;
    // command stays valid for 20 cycles into a write-0 slot
    run_slot(2'd1, 1'b0, 0, 0, 20, nl, nt, bo, rb);
    chk(rb == 0, "R9", "ready seen while busy", rb, 0);
    chk(nl == 60 * F, "R9", "low cycles with held command", nl, 60 * F);
    chk(nt == 70 * F + 1, "R9", "strobe cycle with held command", nt, 70 * F + 1);
    quiet("R9", 100);
  endtask

  task automatic t_abort;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd1; cmd_bit = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (100) @(negedge clk);
    chk(line_drive_low == 1'b1, "R11", "low before abort", line_drive_low, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(line_drive_low == 1'b0, "R11", "drive after abort", line_drive_low, 0);
    chk(cmd_ready == 1'b1, "R11", "ready after abort", cmd_ready, 1);
    quiet("R11", 800);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_write1();
    t_write0();
    t_read();
    t_presence();
    t_touch();
    t_busy();
    t_abort();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule